// File: doc/BRIEF.md
# Shadow Register Copy Sequencer

This block keeps eight bus-writable registers in step with copies held in a slow, always-on clock domain. A write from the fast bus lands at once in the bus-side register and marks that register stale. A sequencer then copies the stale registers to the slow side one at a time. Each copy lasts a fixed number of slow-domain ticks. When a copy ends, the sequencer clears the matching stale flag and raises a sticky "new" flag.

Software finds out when a written value has taken effect by polling the stale flags in a status word. It acknowledges finished copies by writing ones to the new-flag bits. The slow domain is modelled as a single-cycle enable tick (`slowTick`) in the bus clock domain. Each finished copy is shown on a one-cycle write strobe with its index and value.

Top module: `shadow_copy_seq`

## Requirements
- R1: After reset, all stale and new flags are zero, `slowWe` is low and the status word reads 0.
- R2: The bus-side registers sit at these byte addresses: seconds at 0x30 and alarm at 0x40. The six persistent registers sit at 0x60 + 0x10·k (k = 0..5). A write to any of them reads back on `rdData` in the next cycle.
- R3: A write to a shadowed register sets its stale flag in the next cycle. The flag index is k for persistent k, 6 for alarm and 7 for seconds. The status word at 0x10 shows the stale flags in bits [23:16] and the new flags in bits [15:8].
- R4: When several flags are stale, the lowest index is copied first, so the persistent registers go before the alarm and the seconds register goes last.
- R5: Only one copy is in flight at a time. A copy starts on the first clock on which the sequencer is idle and sees a stale flag. It ends on the CopyTicks-th `slowTick` after that start.
- R6: When a copy ends, `slowWe` pulses for one cycle. `slowIdx` and `slowData` then carry the register index and the value that was captured when the copy started. In the same cycle the stale flag clears.
- R7: A new flag is set when its copy ends and stays set until a write to 0x10 with a one in bit 8+i clears it. Zeros in that write have no effect. If a set and a clear fall in the same cycle, the set wins.
- R8: A write to the register whose copy is in flight, including in the cycle the copy starts, keeps its stale flag set. The register is then copied a second time with the newer value.
- R9: Writes to the watchdog register at 0x50, to the status word, or to unmapped addresses set no stale flag. The watchdog value reads back at 0x50 and unmapped addresses read 0.
- R10: A `slowTick` while the sequencer is idle, including the tick on the cycle a copy starts, does not count toward a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Bus write strobe |
| busAddr | input | 8 | Bus write byte address |
| busWdata | input | DataW | Bus write data |
| rdAddr | input | 8 | Read address |
| rdData | output | DataW | Read data for `rdAddr`, combinational |
| slowTick | input | 1 | One-cycle enable marking a slow-domain tick |
| staleFlags | output | 8 | Stale flag per register, in copy order |
| newFlags | output | 8 | Sticky copy-complete flag per register |
| slowWe | output | 1 | One-cycle pulse when a copy ends |
| slowIdx | output | 3 | Index of the register just copied |
| slowData | output | DataW | Value written to the slow-side copy |

## Verification
The properties assume that `busWe`, `busAddr` and `busWdata` are stable around the clock edge, and that `slowTick` is a single-cycle enable that is never undefined after reset. The stimulus changes every input just after a rising edge and holds it for a full cycle. It drives `slowTick` only as a level for whole cycles, and it keeps reset low from time zero until the first edges have passed. Writes that clear new flags are issued only at the status address, so the W1C property sees clean one-cycle writes.

// File: rtl/shadow_seq_pkg.sv
package shadow_seq_pkg;

  localparam int NumRegs    = 8;
  localparam int IdxW       = $clog2(NumRegs);
  localparam int AddrW      = 8;
  localparam int NumPersist = 6;
  localparam int AlarmIdx   = 6;
  localparam int SecondsIdx = 7;
  localparam int StaleLsb   = 16;
  localparam int NewLsb     = 8;

  localparam logic [AddrW-1:0] StatusAddr   = 8'h10;
  localparam logic [AddrW-1:0] SecondsAddr  = 8'h30;
  localparam logic [AddrW-1:0] AlarmAddr    = 8'h40;
  localparam logic [AddrW-1:0] WatchdogAddr = 8'h50;
  localparam logic [AddrW-1:0] PersistBase  = 8'h60;
  localparam logic [AddrW-1:0] PersistStep  = 8'h10;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic            busy;
    logic            launch;
    logic            finish;
    logic [IdxW-1:0] idx;
  } seqStrobe_t;

  // Returns {hit, index} for a shadowed register address
  function automatic logic [IdxW:0] decodeReg(input logic [AddrW-1:0] addr);
    logic [IdxW:0] res;
    res = '0;
    if (addr == SecondsAddr) begin
      res = {1'b1, IdxW'(SecondsIdx)};
    end else if (addr == AlarmAddr) begin
      res = {1'b1, IdxW'(AlarmIdx)};
    end else begin
      for (int k = 0; k < NumPersist; k++) begin
        if (addr == AddrW'(int'(PersistBase) + k * int'(PersistStep))) begin
          res = {1'b1, IdxW'(k)};
        end
      end
    end
    return res;
  endfunction

  // Lowest set bit wins: this is the copy priority
  function automatic logic [IdxW-1:0] firstSet(input logic [NumRegs-1:0] vec);
    logic [IdxW-1:0] pick;
    pick = '0;
    for (int i = NumRegs - 1; i >= 0; i--) begin
      if (vec[i]) pick = IdxW'(i);
    end
    return pick;
  endfunction

endpackage

// File: rtl/shadow_seq_ctrl.sv
module shadow_seq_ctrl
  import shadow_seq_pkg::*;
#(
  parameter int CopyTicks = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slowTick,
  input  logic [NumRegs-1:0] staleVec,
  output seqStrobe_t         strobe
);

  localparam int CntW = (CopyTicks > 1) ? $clog2(CopyTicks) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(CopyTicks - 1);

  typedef enum logic {SEQ_IDLE, SEQ_COPY} seqState_e;

  seqState_e       state;
  logic [CntW-1:0] tickCnt;
  logic [IdxW-1:0] idxQ;
  logic            launchNow;
  logic            finishNow;
  logic [IdxW-1:0] pickIdx;

  always_comb begin
    pickIdx   = firstSet(staleVec);
    launchNow = (state == SEQ_IDLE) && (|staleVec);
    finishNow = (state == SEQ_COPY) && slowTick && (tickCnt == LastCnt);
    strobe.busy   = (state == SEQ_COPY);
    strobe.launch = launchNow;
    strobe.finish = finishNow;
    strobe.idx    = (state == SEQ_IDLE) ? pickIdx : idxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      tickCnt <= '0;
      idxQ    <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (launchNow) begin
            state   <= SEQ_COPY;
            idxQ    <= pickIdx;
            tickCnt <= '0;
          end
        end
        SEQ_COPY: begin
          if (slowTick) begin
            if (tickCnt == LastCnt) begin
              state   <= SEQ_IDLE;
              tickCnt <= '0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shadow_seq_dp.sv
module shadow_seq_dp
  import shadow_seq_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [AddrW-1:0]   busAddr,
  input  logic [DataW-1:0]   busWdata,
  input  logic [AddrW-1:0]   rdAddr,
  input  seqStrobe_t         strobe,
  output logic [DataW-1:0]   rdData,
  output logic [NumRegs-1:0] staleVec,
  output logic [NumRegs-1:0] newVec,
  output logic               slowWe,
  output logic [IdxW-1:0]    slowIdx,
  output logic [DataW-1:0]   slowData
);

  logic [DataW-1:0] busRegs [NumRegs];
  logic [DataW-1:0] wdReg;
  logic [DataW-1:0] snapData;
  logic             reArm;
  logic [IdxW:0]    wDec;
  logic [IdxW:0]    rDec;
  logic             wSel;
  logic             statusWr;
  logic             hitInflight;

  assign wDec        = decodeReg(busAddr);
  assign rDec        = decodeReg(rdAddr);
  assign wSel        = busWe && wDec[IdxW];
  assign statusWr    = busWe && (busAddr == StatusAddr);
  assign hitInflight = wSel && (strobe.busy || strobe.launch) &&
                       (wDec[IdxW-1:0] == strobe.idx);

  for (genvar i = 0; i < NumRegs; i++) begin : g_reg
    logic setHit;
    logic doneHit;
    logic clrHit;

    assign setHit  = wSel && (wDec[IdxW-1:0] == IdxW'(i));
    assign doneHit = strobe.finish && (strobe.idx == IdxW'(i));
    assign clrHit  = statusWr && busWdata[NewLsb + i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busRegs[i]  <= '0;
        staleVec[i] <= 1'b0;
        newVec[i]   <= 1'b0;
      end else begin
        if (setHit) busRegs[i] <= busWdata;
        staleVec[i] <= setHit || (staleVec[i] && !(doneHit && !reArm));
        newVec[i]   <= doneHit || (newVec[i] && !clrHit);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdReg    <= '0;
      snapData <= '0;
      reArm    <= 1'b0;
      slowWe   <= 1'b0;
      slowIdx  <= '0;
      slowData <= '0;
    end else begin
      if (busWe && (busAddr == WatchdogAddr)) wdReg <= busWdata;
      if (strobe.launch) snapData <= busRegs[strobe.idx];
      if (strobe.finish)      reArm <= 1'b0;
      else if (strobe.launch) reArm <= hitInflight;
      else if (hitInflight)   reArm <= 1'b1;
      slowWe <= strobe.finish;
      if (strobe.finish) begin
        slowIdx  <= strobe.idx;
        slowData <= snapData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == StatusAddr) begin
      rdData[StaleLsb +: NumRegs] = staleVec;
      rdData[NewLsb +: NumRegs]   = newVec;
    end else if (rdAddr == WatchdogAddr) begin
      rdData = wdReg;
    end else if (rDec[IdxW]) begin
      rdData = busRegs[rDec[IdxW-1:0]];
    end
  end

endmodule

// File: rtl/shadow_copy_seq.sv
module shadow_copy_seq
  import shadow_seq_pkg::*;
#(
  parameter int DataW     = 32,
  parameter int CopyTicks = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [AddrW-1:0]   busAddr,
  input  logic [DataW-1:0]   busWdata,
  input  logic [AddrW-1:0]   rdAddr,
  output logic [DataW-1:0]   rdData,
  input  logic               slowTick,
  output logic [NumRegs-1:0] staleFlags,
  output logic [NumRegs-1:0] newFlags,
  output logic               slowWe,
  output logic [IdxW-1:0]    slowIdx,
  output logic [DataW-1:0]   slowData
);

  seqStrobe_t seqStrobe;

  shadow_seq_ctrl #(.CopyTicks(CopyTicks)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slowTick (slowTick),
    .staleVec (staleFlags),
    .strobe   (seqStrobe)
  );

  shadow_seq_dp #(.DataW(DataW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .rdAddr   (rdAddr),
    .strobe   (seqStrobe),
    .rdData   (rdData),
    .staleVec (staleFlags),
    .newVec   (newFlags),
    .slowWe   (slowWe),
    .slowIdx  (slowIdx),
    .slowData (slowData)
  );

endmodule

// File: rtl/shadow_copy_seq_chk.sv
module shadow_copy_seq_chk
  import shadow_seq_pkg::*;
#(
  parameter int DataW = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic [AddrW-1:0]   busAddr,
  input logic [DataW-1:0]   busWdata,
  input logic [NumRegs-1:0] staleFlags,
  input logic [NumRegs-1:0] newFlags,
  input logic               slowWe,
  input logic [IdxW-1:0]    slowIdx
);

  logic [IdxW:0] wDec;
  assign wDec = decodeReg(busAddr);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (staleFlags == '0) && (newFlags == '0) && !slowWe);

  assert_stale_on_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && wDec[IdxW]) |=> staleFlags[$past(wDec[IdxW-1:0])]);

  assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rstN)
    slowWe |=> !slowWe);

  assert_done_marks_new_R6: assert property (@(posedge clk) disable iff (!rstN)
    slowWe |-> newFlags[slowIdx]);

  assert_w1c_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr == StatusAddr) && (busWdata[NewLsb +: NumRegs] == '1))
      |=> (newFlags == (slowWe ? (NumRegs'(1) << slowIdx) : '0)));

  assert_no_stale_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !wDec[IdxW]) |=> ((staleFlags & ~$past(staleFlags)) == '0));

endmodule

bind shadow_copy_seq shadow_copy_seq_chk #(.DataW(DataW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .staleFlags (staleFlags),
  .newFlags   (newFlags),
  .slowWe     (slowWe),
  .slowIdx    (slowIdx)
);

// File: tb/sim_shadow_copy_seq.sv
module sim_shadow_copy_seq;

  localparam int ClkPeriod = 10;
  localparam int CopyTicks = 4;
  localparam int DataW     = 32;
  localparam int WdCycles  = 20000;

  // {address, data, expected index}
  localparam logic [47:0] VecTab [6] = '{
    {8'h60, 32'hA5A5_0001, 8'd0},
    {8'h70, 32'h1234_5678, 8'd1},
    {8'hA0, 32'h0BAD_F00D, 8'd4},
    {8'h40, 32'h0000_4E20, 8'd6},
    {8'h30, 32'h6000_0001, 8'd7},
    {8'hB0, 32'hFFFF_0000, 8'd5}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWe = 1'b0;
  logic [7:0]       busAddr = '0;
  logic [DataW-1:0] busWdata = '0;
  logic [7:0]       rdAddr = '0;
  logic [DataW-1:0] rdData;
  logic             slowTick = 1'b0;
  logic [7:0]       staleFlags;
  logic [7:0]       newFlags;
  logic             slowWe;
  logic [2:0]       slowIdx;
  logic [DataW-1:0] slowData;

  int total = 0;
  int bad   = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  shadow_copy_seq #(.DataW(DataW), .CopyTicks(CopyTicks)) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .rdAddr(rdAddr), .rdData(rdData),
    .slowTick(slowTick), .staleFlags(staleFlags), .newFlags(newFlags),
    .slowWe(slowWe), .slowIdx(slowIdx), .slowData(slowData)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    cyc();
    busWe = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  // Ticks every cycle until slowWe is seen; returns the tick count
  task automatic tickUntilDone(output int n);
    n = 0;
    slowTick = 1'b1;
    for (int k = 0; k < 40; k++) begin
      cyc();
      n++;
      if (slowWe) break;
    end
    slowTick = 1'b0;
  endtask

  initial begin
    repeat (WdCycles) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] order [5];
    int got;

    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    rdAddr = 8'h10;
    #1;
    checkEq("R1 stale", staleFlags, 8'h00);
    checkEq("R1 new", newFlags, 8'h00);
    checkEq("R1 slowWe", slowWe, 0);
    checkEq("R1 status", rdData, 0);

    // Table walk: single writes, each copied on its own
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [2:0]  ix;
      a  = VecTab[v][47:40];
      d  = VecTab[v][39:8];
      ix = VecTab[v][2:0];
      busWrite(a, d);
      checkEq("R3 stale set", staleFlags, 8'(1) << ix);
      rdAddr = a; #1;
      checkEq("R2 readback", rdData, d);
      rdAddr = 8'h10; #1;
      checkEq("R3 status field", rdData[23:16], 8'(1) << ix);
      cyc();
      tickUntilDone(n);
      checkEq("R5 tick count", n, CopyTicks);
      checkEq("R6 slowIdx", slowIdx, ix);
      checkEq("R6 slowData", slowData, d);
      checkEq("R6 stale cleared", staleFlags, 8'h00);
      checkEq("R7 new set", newFlags, 8'(1) << ix);
      cyc();
      checkEq("R6 pulse one cycle", slowWe, 0);
      busWrite(8'h10, 32'(1) << (8 + ix));
      checkEq("R7 new cleared", newFlags, 8'h00);
    end

    // R4 priority: start persistent 5, then queue others during its copy
    busWrite(8'hB0, 32'h5);
    busWrite(8'h30, 32'h7);
    busWrite(8'h40, 32'h6);
    busWrite(8'h80, 32'h2);
    busWrite(8'h60, 32'h0);
    checkEq("R4 stale set queued", staleFlags, 8'hE5);
    got = 0;
    slowTick = 1'b1;
    for (int k = 0; k < 200 && got < 5; k++) begin
      cyc();
      if (slowWe) begin
        order[got] = slowIdx;
        got++;
      end
    end
    slowTick = 1'b0;
    checkEq("R4 copies", got, 5);
    checkEq("R4 first", order[0], 5);
    checkEq("R4 second", order[1], 0);
    checkEq("R4 third", order[2], 2);
    checkEq("R4 fourth alarm", order[3], 6);
    checkEq("R4 seconds last", order[4], 7);
    checkEq("R4 all clear", staleFlags, 8'h00);
    busWrite(8'h10, 32'h0000_FF00);
    checkEq("R7 clear all", newFlags, 8'h00);

    // R8 rewrite during flight
    busWrite(8'h70, 32'hAAAA_0001);
    cyc();
    slowTick = 1'b1; cyc(); slowTick = 1'b0;
    busWrite(8'h70, 32'hBBBB_0002);
    tickUntilDone(n);
    checkEq("R8 first copy old value", slowData, 32'hAAAA_0001);
    checkEq("R8 stale kept", staleFlags, 8'h02);
    tickUntilDone(n);
    checkEq("R8 second copy new value", slowData, 32'hBBBB_0002);
    checkEq("R8 stale cleared", staleFlags, 8'h00);

    // R8 rewrite in the launch cycle
    busWrite(8'h30, 32'h0000_0011);
    busWrite(8'h30, 32'h0000_0022);
    tickUntilDone(n);
    checkEq("R8 launch-cycle old", slowData, 32'h0000_0011);
    checkEq("R8 launch-cycle stale", staleFlags, 8'h80);
    tickUntilDone(n);
    checkEq("R8 launch-cycle new", slowData, 32'h0000_0022);
    busWrite(8'h10, 32'h0000_FF00);

    // R9 non-shadowed writes
    busWrite(8'h50, 32'h0000_1234);
    checkEq("R9 watchdog no stale", staleFlags, 8'h00);
    rdAddr = 8'h50; #1;
    checkEq("R9 watchdog readback", rdData, 32'h0000_1234);
    busWrite(8'h10, 32'h00FF_0000);
    checkEq("R9 status write no stale", staleFlags, 8'h00);
    busWrite(8'h20, 32'hFFFF_FFFF);
    checkEq("R9 unmapped no stale", staleFlags, 8'h00);
    rdAddr = 8'h20; #1;
    checkEq("R9 unmapped reads zero", rdData, 0);

    // R7 selective clear and zero writes
    busWrite(8'h90, 32'h3);
    busWrite(8'hA0, 32'h4);
    tickUntilDone(n);
    tickUntilDone(n);
    checkEq("R7 two set", newFlags, 8'h18);
    busWrite(8'h10, 32'h0);
    checkEq("R7 zero write no effect", newFlags, 8'h18);
    busWrite(8'h10, 32'h0000_0800);
    checkEq("R7 clear one bit", newFlags, 8'h10);
    rdAddr = 8'h10; #1;
    checkEq("R7 status new field", rdData[15:8], 8'h10);
    busWrite(8'h10, 32'h0000_FF00);

    // R10 idle ticks ignored, launch-cycle tick ignored
    slowTick = 1'b1;
    got = 0;
    for (int k = 0; k < 10; k++) begin
      cyc();
      if (slowWe) got++;
    end
    slowTick = 1'b0;
    checkEq("R10 idle ticks no copy", got, 0);
    checkEq("R10 idle stale", staleFlags, 8'h00);
    busWrite(8'h40, 32'h99);
    slowTick = 1'b1; cyc(); slowTick = 1'b0;
    checkEq("R10 no copy at launch", slowWe, 0);
    tickUntilDone(n);
    checkEq("R10 launch tick not counted", n, CopyTicks);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule